// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a successive-approximation analog-to-digital converter. It drives a trial code to an external DAC and reads back one comparator bit that says whether the DAC output is above the held analog input. A single token travels through an N-stage shift register, one stage per clock, from the most significant bit down to the least significant bit. In the cycle that holds the token for a bit, that bit is set in the trial code. When the token moves on, the bit is cleared if the comparator reported the DAC above the input; otherwise the bit is kept. Each step halves the range the input can still lie in, so every conversion takes exactly N trial cycles however large the input is.

A start request accepted while the block is idle produces a one-cycle sample strobe for the external sample-and-hold. The token then enters the MSB stage. The final stage is the end-of-conversion indication, and it also loads the decided code into the result register. That register keeps its old value at all other times. With continuous mode enabled, each end-of-conversion starts the next sample strobe directly, which gives a fixed period of N+1 cycles per conversion.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is applied and once it is released, `busy`, `eoc`, `sh_strobe`, `dac_code` and `result` are all zero until a conversion is started.
- R2: A `soc` high at a clock edge while `busy` is low makes `sh_strobe` high for exactly the next cycle, and `busy` is high from that cycle on.
- R3: After the strobe cycle there are exactly N trial cycles, one per bit from bit N-1 down to bit 0. `eoc` is high only in the bit-0 cycle.
- R4: In the trial cycle for bit k, `dac_code` holds the bits already decided above k, has bit k set to 1, and has all bits below k at 0.
- R5: A trial bit is kept when `cmp_hi` (1 = DAC code above the input) is 0 in its trial cycle and is cleared when `cmp_hi` is 1. The final value is therefore the largest code not above the input.
- R6: `result` takes the final code at the clock edge that ends the `eoc` cycle and holds its value at every other edge.
- R7: An input above the largest code converts to all ones.
- R8: `soc` is ignored while `busy` is high. The running conversion keeps its timing and result, and no extra strobe follows.
- R9: With `cont_en` high during the `eoc` cycle, `sh_strobe` is high in the very next cycle, so conversions repeat every N+1 cycles.
- R10: With `cont_en` low during the `eoc` cycle, `busy` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soc | input | 1 | Start-of-conversion request, accepted when idle |
| cont_en | input | 1 | Continuous re-sampling enable |
| cmp_hi | input | 1 | Comparator: 1 when the DAC output is above the held input |
| dac_code | output | N | Trial code to the DAC |
| result | output | N | Latched result of the last conversion |
| busy | output | 1 | High from the sample strobe through end-of-conversion |
| eoc | output | 1 | End of conversion, high during the LSB trial |
| sh_strobe | output | 1 | One-cycle strobe to the sample-and-hold |

## Verification
The assertions assume that `cmp_hi` is a function of the current `dac_code` and of an input that stays fixed for the whole conversion, and that `soc` is a clean synchronous level after reset. The bench models the comparator as a combinational comparison of `dac_code` against a target value. It changes that target only in the strobe cycle or while idle, and it drives `soc` and `cont_en` on falling edges. Random targets cover both the in-range values and values above full scale, and directed cases add zero, full scale, mid-scale neighbours and starts requested during a conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

  parameter int unsigned SAR_BITS_DEF = 8;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2
  } sar_phase_e;

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/sar_token_seq.sv
module sar_token_seq #(
  parameter int unsigned N = sar_pkg::SAR_BITS_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  output logic         samp,
  output logic [N-1:0] tok,
  output logic         last,
  output sar_pkg::sar_phase_e phase
);
  import sar_pkg::*;

  localparam logic [N-1:0] TOK_MSB = {1'b1, {(N-1){1'b0}}};

  logic         samp_q, samp_d;
  logic [N-1:0] tok_q, tok_d;

  always_comb begin
    samp_d = launch;
    if (samp_q) tok_d = TOK_MSB;
    else        tok_d = tok_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      tok_q  <= '0;
    end else begin
      samp_q <= samp_d;
      tok_q  <= tok_d;
    end
  end

  always_comb begin
    if (samp_q)      phase = PH_SAMPLE;
    else if (|tok_q) phase = PH_TRIAL;
    else             phase = PH_IDLE;
  end

  assign samp = samp_q;
  assign tok  = tok_q;
  assign last = tok_q[0];
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int unsigned N = sar_pkg::SAR_BITS_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] tok,
  input  logic         cmp_hi,
  output logic [N-1:0] trial,
  output logic [N-1:0] decided
);
  logic [N-1:0] code_q, code_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (tok[i]) decided[i] = ~cmp_hi;
      else        decided[i] = code_q[i];
      if (clear)  code_d[i]  = 1'b0;
      else        code_d[i]  = decided[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign trial = code_q | tok;
endmodule

// File: rtl/sar_result_hold.sv
module sar_result_hold #(
  parameter int unsigned N = sar_pkg::SAR_BITS_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] res_q, res_d;

  always_comb begin
    if (load) res_d = d;
    else      res_d = res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign q = res_q;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int unsigned N = sar_pkg::SAR_BITS_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soc,
  input  logic         cont_en,
  input  logic         cmp_hi,
  output logic [N-1:0] dac_code,
  output logic [N-1:0] result,
  output logic         busy,
  output logic         eoc,
  output logic         sh_strobe
);
  import sar_pkg::*;

  logic         rst_n_s;
  logic         launch;
  logic         samp;
  logic         last;
  logic [N-1:0] tok;
  logic [N-1:0] decided;
  sar_phase_e   phase;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  assign busy   = (phase != PH_IDLE);
  assign launch = (soc & ~busy) | (last & cont_en);

  sar_token_seq #(.N(N)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .launch (launch),
    .samp   (samp),
    .tok    (tok),
    .last   (last),
    .phase  (phase)
  );

  sar_bit_reg #(.N(N)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clear   (samp),
    .tok     (tok),
    .cmp_hi  (cmp_hi),
    .trial   (dac_code),
    .decided (decided)
  );

  sar_result_hold #(.N(N)) u_res (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (last),
    .d     (decided),
    .q     (result)
  );

  assign eoc       = last;
  assign sh_strobe = samp;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         soc,
  input logic         cont_en,
  input logic         cmp_hi,
  input logic [N-1:0] dac_code,
  input logic [N-1:0] result,
  input logic         busy,
  input logic         eoc,
  input logic         sh_strobe
);
  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  a_r2_start_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (soc && !busy) |=> (sh_strobe && busy));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |=> !sh_strobe);

  a_r3_eoc_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (busy && !sh_strobe));

  a_r4_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |=> (dac_code == MSB_ONLY));

  a_r5_lsb_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !cmp_hi) |=> result[0]);

  a_r5_lsb_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && cmp_hi) |=> !result[0]);

  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |=> $stable(result));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eoc) |=> !sh_strobe);

  a_r9_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && cont_en) |=> sh_strobe);

  a_r10_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !cont_en) |=> !busy);
endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .soc       (soc),
  .cont_en   (cont_en),
  .cmp_hi    (cmp_hi),
  .dac_code  (dac_code),
  .result    (result),
  .busy      (busy),
  .eoc       (eoc),
  .sh_strobe (sh_strobe)
);

// File: tb/sar_ctrl_bench.sv
module sar_ctrl_bench;
  localparam int N    = 8;
  localparam int FULL = (1 << N) - 1;

  logic         clk;
  logic         rst_n;
  logic         soc;
  logic         cont_en;
  logic         cmp_hi;
  logic [N-1:0] dac_code;
  logic [N-1:0] result;
  logic         busy;
  logic         eoc;
  logic         sh_strobe;

  int target;
  int n_chk;
  int n_bad;
  int last_exp;
  int cyc;
  bit done;

  sar_ctrl #(.N(N)) u_sar_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soc       (soc),
    .cont_en   (cont_en),
    .cmp_hi    (cmp_hi),
    .dac_code  (dac_code),
    .result    (result),
    .busy      (busy),
    .eoc       (eoc),
    .sh_strobe (sh_strobe)
  );

  // comparator model: 1 when the DAC code is above the held input
  assign cmp_hi = (int'(dac_code) > target);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int expect_code(input int tgt);
    return (tgt > FULL) ? FULL : tgt;
  endfunction

  function automatic int trial_code(input int fin, input int k);
    return ((fin >> (k + 1)) << (k + 1)) | (1 << k);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // one conversion in single-shot mode; poke requests a start mid-conversion
  task automatic convert(input int tgt, input bit poke);
    int fin;
    fin = expect_code(tgt);
    target = tgt;
    soc = 1'b1;
    @(negedge clk);
    soc = 1'b0;
    check("R2 strobe", int'(sh_strobe), 1);
    check("R2 busy", int'(busy), 1);
    for (int k = N - 1; k >= 0; k--) begin
      @(negedge clk);
      check("R4 R5 trial code", int'(dac_code), trial_code(fin, k));
      check("R3 eoc timing", int'(eoc), (k == 0) ? 1 : 0);
      check("R6 result held", int'(result), last_exp);
      check("R8 no strobe", int'(sh_strobe), 0);
      soc = (poke && k == N / 2) ? 1'b1 : 1'b0;
    end
    @(negedge clk);
    soc = 1'b0;
    check(tgt > FULL ? "R7 overrange" : "R6 result", int'(result), fin);
    check("R10 idle", int'(busy), 0);
    check("R8 no restart", int'(sh_strobe), 0);
    last_exp = fin;
  endtask

  task automatic cont_run(input int count);
    int fin;
    cont_en = 1'b1;
    target = int'($urandom_range(FULL + 10, 0));
    soc = 1'b1;
    @(negedge clk);
    soc = 1'b0;
    for (int c = 0; c < count; c++) begin
      check("R9 strobe", int'(sh_strobe), 1);
      fin = expect_code(target);
      for (int k = N - 1; k >= 0; k--) begin
        @(negedge clk);
        check("R9 R4 trial code", int'(dac_code), trial_code(fin, k));
        check("R9 R3 eoc timing", int'(eoc), (k == 0) ? 1 : 0);
        if (k == 0 && c == count - 1) cont_en = 1'b0;
      end
      @(negedge clk);
      check("R9 R6 result", int'(result), fin);
      last_exp = fin;
      if (c < count - 1) target = int'($urandom_range(FULL + 10, 0));
    end
    check("R10 idle after continuous", int'(busy), 0);
    check("R10 no strobe", int'(sh_strobe), 0);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    n_chk = 0;
    n_bad = 0;
    last_exp = 0;
    done = 1'b0;
    target = 0;
    soc = 1'b0;
    cont_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 eoc", int'(eoc), 0);
    check("R1 strobe", int'(sh_strobe), 0);
    check("R1 dac_code", int'(dac_code), 0);
    check("R1 result", int'(result), 0);

    convert(0, 1'b0);
    convert(FULL, 1'b0);
    convert(FULL + 1, 1'b0);      // R7
    convert(FULL + 200, 1'b0);    // R7
    convert(1 << (N - 1), 1'b1);  // R8
    convert((1 << (N - 1)) - 1, 1'b1);
    convert(1, 1'b0);
    for (int i = 0; i < 120; i++)
      convert(int'($urandom_range(FULL + 40, 0)), i[2]);
    cont_run(6);
    repeat (3) @(negedge clk);
    convert(int'($urandom_range(FULL, 0)), 1'b0);
    cont_run(12);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule